// File: doc/BRIEF.md
# Paravirtual Device Register Window

This block is the register window a guest driver uses to set up a paravirtual queue device. It exposes a small header of control registers followed by a device-specific configuration byte area. Through the header the driver reads the features the device offers and writes back the ones it accepts. It picks a queue, reads that queue's fixed depth, programs the queue's page frame number, rings a doorbell for a queue, and steps through the device status byte. It also reads and acknowledges the interrupt status.

The bus is a single-cycle slave. Read data is combinational on the cycle the access is presented, and every side effect of a read or a write takes place at the clock edge that ends the access. A write of zero to the page frame number or to the status byte causes a device reset, and `dev_reset` pulses one cycle later. A doorbell write gives a one-cycle `notify_valid` pulse that carries the queue index. The interrupt output is a level signal that follows bit 0 of the interrupt status byte. An internal request input sets that bit, and a read of the byte clears it.

Top module: `pvdev_regwin`

## Requirements
- R1: After `rst`, the accepted features, queue select, status, interrupt status and every queue page frame number read as zero, `irq` is low, and `notify_valid` and `dev_reset` are low.
- R2: A read at offset 0 returns the `HOST_FEAT` parameter ORed with bits 24, 28 and 30 (the always-offered bits). Writes to that offset have no effect.
- R3: A write at offset 4 stores the write data as the accepted features, and a read at offset 4 returns them. If bit 30 of the write data is set, `FALLBACK_FEAT` is stored instead, or zero when `HAS_FALLBACK` is 0.
- R4: A write at offset 14 changes the selected queue only when bits 15:0 of the write data are below `NQ`. Any other value leaves the selection as it was. A read at offset 14 returns the selection.
- R5: A nonzero write at offset 8 stores a page frame number for the selected queue. A read at offset 8 returns the stored number for the selected queue, and `q_base` equals that number shifted left by 12.
- R6: A read at offset 12 returns the fixed depth of the selected queue, which is `DEPTH_BASE*(index+1)`.
- R7: A write at offset 16 makes `notify_valid` high for exactly the cycle after the write, with `notify_queue` equal to bits 15:0 of the write data.
- R8: A write at offset 18 stores bits 7:0 of the write data as the status byte, and a read at offset 18 returns it.
- R9: A write of zero at offset 8, or a write at offset 18 whose bits 7:0 are zero, pulses `dev_reset` in the next cycle. In the same edge it clears the accepted features, the queue select, the status, the interrupt status and the page frame numbers of all queues. The configuration bytes are kept.
- R10: A read at offset 19 returns the interrupt status byte in bits 7:0 and clears it at the end of the access, so `irq` is low in the next cycle.
- R11: `irq_req` high in a cycle sets bit 0 of the interrupt status at that cycle's edge, even when the same cycle also reads offset 19 or causes a device reset. `irq` is high whenever that bit is set.
- R12: Reads of header offsets 1-3, 5-7, 9-11, 13, 15, 16 and 17, and reads at or above the window size (the next power of two at or above 20+`CFG_LEN`), return 32'hFFFFFFFF. Writes beyond the window have no effect.
- R13: Offsets from 20 up to the window end access configuration byte `offset-20` little-endian. `bus_size` 0, 1 or 2 moves 1, 2 or 4 bytes, and unused read lanes are zero. Bytes at or past `CFG_LEN` read as 8'hFF and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset into the window |
| bus_size | input | 2 | 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_req | input | 1 | Internal interrupt request |
| irq | output | 1 | Level interrupt |
| notify_valid | output | 1 | Doorbell pulse |
| notify_queue | output | 16 | Queue index of the doorbell |
| dev_reset | output | 1 | Device reset pulse |
| q_base | output | PFN_W+12 | Base address of the selected queue |

## Verification
The bench attacks the reset triggers. A design that missed the zero-frame-number path would store a zero base. A design that missed the zero-status path would keep stale features and queue addresses. The bench also checks the select range at `NQ` and at 16'hFFFF, where a design with an off-by-one in the range check would move the selection and corrupt a neighbouring queue's address. It drives an interrupt request in the same cycle as a status read: a design in which the read-clear wins would lose that event and leave `irq` low. Random accesses of mixed size cover the header holes, the edge of the configuration area and the space past the window, where a wrong decode returns data instead of all ones.

// File: rtl/pvdev_pkg.sv
package pvdev_pkg;

    // header layout (offsets are decoded by the guest driver)
    localparam int OFF_HFEAT  = 0;
    localparam int OFF_GFEAT  = 4;
    localparam int OFF_PFN    = 8;
    localparam int OFF_QDEPTH = 12;
    localparam int OFF_QSEL   = 14;
    localparam int OFF_NOTIFY = 16;
    localparam int OFF_STATUS = 18;
    localparam int OFF_ISR    = 19;
    localparam int OFF_CFG    = 20;

    localparam int FEAT_EMPTY_NOTIFY = 24;
    localparam int FEAT_INDIRECT     = 28;
    localparam int FEAT_BAD_NEGOT    = 30;
    localparam int PAGE_SHIFT        = 12;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_HFEAT,
        RG_GFEAT,
        RG_PFN,
        RG_QDEPTH,
        RG_QSEL,
        RG_NOTIFY,
        RG_STATUS,
        RG_ISR,
        RG_CFG
    } reg_sel_e;

    typedef struct packed {
        logic [31:0] gfeat;
        logic [7:0]  status;
    } ctrl_regs_t;

    function automatic int win_bytes(int cfg_len);
        int need;
        int p;
        need = OFF_CFG + cfg_len;
        p = 1;
        while (p < need) p = p * 2;
        return p;
    endfunction

    function automatic logic [15:0] queue_depth(int base, int idx);
        return 16'(base * (idx + 1));
    endfunction

    function automatic logic [31:0] offered_bits();
        logic [31:0] m;
        m = '0;
        m[FEAT_EMPTY_NOTIFY] = 1'b1;
        m[FEAT_INDIRECT]     = 1'b1;
        m[FEAT_BAD_NEGOT]    = 1'b1;
        return m;
    endfunction

    function automatic int size_bytes(acc_size_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/pvdev_decode.sv
module pvdev_decode
    import pvdev_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CFG_LEN = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [ADDR_W-1:0] cfg_off
);
    localparam int WIN = win_bytes(CFG_LEN);

    always_comb begin
        int a;
        a = int'(addr);
        cfg_off = addr - ADDR_W'(OFF_CFG);
        if (a >= WIN) begin
            sel = RG_NONE;
        end else if (a >= OFF_CFG) begin
            sel = RG_CFG;
        end else begin
            case (a)
                OFF_HFEAT:  sel = RG_HFEAT;
                OFF_GFEAT:  sel = RG_GFEAT;
                OFF_PFN:    sel = RG_PFN;
                OFF_QDEPTH: sel = RG_QDEPTH;
                OFF_QSEL:   sel = RG_QSEL;
                OFF_NOTIFY: sel = RG_NOTIFY;
                OFF_STATUS: sel = RG_STATUS;
                OFF_ISR:    sel = RG_ISR;
                default:    sel = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pvdev_queue_bank.sv
module pvdev_queue_bank
    import pvdev_pkg::*;
#(
    parameter int NQ         = 4,
    parameter int PFN_W      = 32,
    parameter int DEPTH_BASE = 128,
    localparam int IDX_W     = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [PFN_W-1:0] wr_pfn,
    output logic [PFN_W-1:0] rd_pfn,
    output logic [15:0]      rd_depth
);
    logic [PFN_W-1:0] pfn_q [NQ];
    logic [15:0]      depth [NQ];

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        assign depth[q] = queue_depth(DEPTH_BASE, q);

        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                pfn_q[q] <= '0;
            end else if (wr_en && int'(idx) == q) begin
                pfn_q[q] <= wr_pfn;
            end
        end
    end

    always_comb begin
        rd_pfn   = '0;
        rd_depth = '0;
        for (int q = 0; q < NQ; q++) begin
            if (int'(idx) == q) begin
                rd_pfn   = pfn_q[q];
                rd_depth = depth[q];
            end
        end
    end
endmodule

// File: rtl/pvdev_isr_unit.sv
module pvdev_isr_unit (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_req,
    input  logic       rd_clr,
    input  logic       dev_clr,
    output logic [7:0] isr,
    output logic       irq
);
    logic [7:0] isr_q;
    logic [7:0] isr_d;

    // a set in the same cycle as any clear wins
    always_comb begin
        isr_d = isr_q;
        if (rd_clr || dev_clr) isr_d = '0;
        if (set_req) isr_d[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= isr_d;
    end

    assign isr = isr_q;
    assign irq = isr_q[0];
endmodule

// File: rtl/pvdev_cfg_space.sv
module pvdev_cfg_space
    import pvdev_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CFG_LEN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] off,
    input  acc_size_e         size,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    logic [8*CFG_LEN-1:0] bytes_flat;
    int                   nbytes;

    assign nbytes = size_bytes(size);

    for (genvar b = 0; b < CFG_LEN; b++) begin : g_byte
        logic [7:0] byte_q;
        logic       hit;
        logic [7:0] wbyte;
        int         rel;

        always_comb begin
            rel   = b - int'(off);
            hit   = wr_en && (rel >= 0) && (rel < nbytes);
            wbyte = wdata[8*(rel & 3) +: 8];
        end

        always_ff @(posedge clk) begin
            if (rst)      byte_q <= '0;
            else if (hit) byte_q <= wbyte;
        end

        assign bytes_flat[8*b +: 8] = byte_q;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < nbytes) begin
                rdata[8*k +: 8] = 8'hFF;
                for (int b = 0; b < CFG_LEN; b++) begin
                    if (int'(off) + k == b) rdata[8*k +: 8] = bytes_flat[8*b +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/pvdev_regwin.sv
module pvdev_regwin
    import pvdev_pkg::*;
#(
    parameter int          ADDR_W        = 8,
    parameter int          NQ            = 4,
    parameter int          PFN_W         = 32,
    parameter int          CFG_LEN       = 8,
    parameter int          DEPTH_BASE    = 128,
    parameter logic [31:0] HOST_FEAT     = 32'h0000_0F21,
    parameter logic [31:0] FALLBACK_FEAT = 32'h0000_0021,
    parameter bit          HAS_FALLBACK  = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [1:0]            bus_size,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic                  irq_req,
    output logic                  irq,
    output logic                  notify_valid,
    output logic [15:0]           notify_queue,
    output logic                  dev_reset,
    output logic [PFN_W+PAGE_SHIFT-1:0] q_base
);
    localparam int IDX_W = (NQ > 1) ? $clog2(NQ) : 1;

    reg_sel_e          sel;
    logic [ADDR_W-1:0] cfg_off;
    acc_size_e         size;
    logic              wr, rd;
    logic              clr_pfn, clr_stat, dev_clr;
    logic              sel_ok;

    ctrl_regs_t        ctrl_q, ctrl_d;
    logic [IDX_W-1:0]  qsel_q, qsel_d;
    logic              notify_q;
    logic [15:0]       notify_idx_q;
    logic              devrst_q;

    logic [PFN_W-1:0]  rd_pfn;
    logic [15:0]       rd_depth;
    logic [7:0]        isr;
    logic [31:0]       cfg_rdata;

    assign size = acc_size_e'(bus_size);
    assign wr   = bus_valid && bus_write;
    assign rd   = bus_valid && !bus_write;

    pvdev_decode #(.ADDR_W(ADDR_W), .CFG_LEN(CFG_LEN)) u_decode (
        .addr    (bus_addr),
        .sel     (sel),
        .cfg_off (cfg_off)
    );

    assign clr_pfn  = wr && (sel == RG_PFN) && (bus_wdata[PFN_W-1:0] == '0);
    assign clr_stat = wr && (sel == RG_STATUS) && (bus_wdata[7:0] == 8'h00);
    assign dev_clr  = clr_pfn || clr_stat;
    assign sel_ok   = bus_wdata[15:0] < 16'(NQ);

    always_comb begin
        ctrl_d = ctrl_q;
        qsel_d = qsel_q;
        if (dev_clr) begin
            ctrl_d = '0;
            qsel_d = '0;
        end else if (wr) begin
            case (sel)
                RG_GFEAT: begin
                    if (bus_wdata[FEAT_BAD_NEGOT])
                        ctrl_d.gfeat = HAS_FALLBACK ? FALLBACK_FEAT : 32'h0;
                    else
                        ctrl_d.gfeat = bus_wdata;
                end
                RG_QSEL:   if (sel_ok) qsel_d = bus_wdata[IDX_W-1:0];
                RG_STATUS: ctrl_d.status = bus_wdata[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            qsel_q       <= '0;
            notify_q     <= 1'b0;
            notify_idx_q <= '0;
            devrst_q     <= 1'b0;
        end else begin
            ctrl_q   <= ctrl_d;
            qsel_q   <= qsel_d;
            notify_q <= wr && (sel == RG_NOTIFY);
            devrst_q <= dev_clr;
            if (wr && (sel == RG_NOTIFY)) notify_idx_q <= bus_wdata[15:0];
        end
    end

    pvdev_queue_bank #(.NQ(NQ), .PFN_W(PFN_W), .DEPTH_BASE(DEPTH_BASE)) u_queues (
        .clk      (clk),
        .rst      (rst),
        .clr_all  (dev_clr),
        .wr_en    (wr && (sel == RG_PFN) && !clr_pfn),
        .idx      (qsel_q),
        .wr_pfn   (bus_wdata[PFN_W-1:0]),
        .rd_pfn   (rd_pfn),
        .rd_depth (rd_depth)
    );

    pvdev_isr_unit u_isr (
        .clk     (clk),
        .rst     (rst),
        .set_req (irq_req),
        .rd_clr  (rd && (sel == RG_ISR)),
        .dev_clr (dev_clr),
        .isr     (isr),
        .irq     (irq)
    );

    pvdev_cfg_space #(.ADDR_W(ADDR_W), .CFG_LEN(CFG_LEN)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr && (sel == RG_CFG)),
        .off   (cfg_off),
        .size  (size),
        .wdata (bus_wdata),
        .rdata (cfg_rdata)
    );

    always_comb begin
        case (sel)
            RG_HFEAT:  bus_rdata = HOST_FEAT | offered_bits();
            RG_GFEAT:  bus_rdata = ctrl_q.gfeat;
            RG_PFN:    bus_rdata = 32'(rd_pfn);
            RG_QDEPTH: bus_rdata = {16'h0, rd_depth};
            RG_QSEL:   bus_rdata = 32'(qsel_q);
            RG_STATUS: bus_rdata = {24'h0, ctrl_q.status};
            RG_ISR:    bus_rdata = {24'h0, isr};
            RG_CFG:    bus_rdata = cfg_rdata;
            default:   bus_rdata = 32'hFFFF_FFFF;
        endcase
    end

    assign notify_valid = notify_q;
    assign notify_queue = notify_idx_q;
    assign dev_reset    = devrst_q;
    assign q_base       = {rd_pfn, {PAGE_SHIFT{1'b0}}};
endmodule

// File: rtl/pvdev_regwin_chk.sv
module pvdev_regwin_chk #(
    parameter int ADDR_W = 8,
    parameter int NQ     = 4,
    parameter int QB_W   = 44
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq_req,
    input logic              irq,
    input logic              notify_valid,
    input logic [15:0]       notify_queue,
    input logic              dev_reset,
    input logic [QB_W-1:0]   q_base
);
    logic wr_at, rd_at;
    assign wr_at = bus_valid && bus_write;
    assign rd_at = bus_valid && !bus_write;

    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        irq_req |=> irq);

    a_r10_isr_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_at && bus_addr == ADDR_W'(19) && !irq_req) |=> !irq);

    a_r7_notify_pulse: assert property (@(posedge clk) disable iff (rst)
        (wr_at && bus_addr == ADDR_W'(16)) |=>
            (notify_valid && notify_queue == $past(bus_wdata[15:0])));

    a_r9_status_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_at && bus_addr == ADDR_W'(18) && bus_wdata[7:0] == 8'h00) |=> dev_reset);

    a_r9_pfn_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_at && bus_addr == ADDR_W'(8) && bus_wdata == 32'h0) |=>
            (dev_reset && q_base == '0));

    a_r5_pfn_store: assert property (@(posedge clk) disable iff (rst)
        (wr_at && bus_addr == ADDR_W'(8) && bus_wdata != 32'h0) |=>
            (q_base == QB_W'({$past(bus_wdata), 12'h000})));

    a_r4_sel_range: assert property (@(posedge clk) disable iff (rst)
        (wr_at && bus_addr == ADDR_W'(14) && bus_wdata[15:0] >= 16'(NQ)) |=> $stable(q_base));

    a_r12_hole_ones: assert property (@(posedge clk) disable iff (rst)
        (rd_at && (bus_addr == ADDR_W'(1) || bus_addr == ADDR_W'(13) || bus_addr == ADDR_W'(17)))
            |-> bus_rdata == 32'hFFFF_FFFF);
endmodule

bind pvdev_regwin pvdev_regwin_chk #(
    .ADDR_W (ADDR_W),
    .NQ     (NQ),
    .QB_W   (PFN_W + 12)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .irq_req      (irq_req),
    .irq          (irq),
    .notify_valid (notify_valid),
    .notify_queue (notify_queue),
    .dev_reset    (dev_reset),
    .q_base       (q_base)
);

// File: tb/pvdev_regwin_bench.sv
`timescale 1ns/1ps
module pvdev_regwin_bench;
    localparam int          AW   = 8;
    localparam int          NQ   = 4;
    localparam int          CLEN = 8;
    localparam int          WIN  = 32;
    localparam logic [31:0] HF   = 32'h0000_0F21;
    localparam logic [31:0] FB   = 32'h0000_0021;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = 2'd2;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_req = 1'b0;
    logic          irq;
    logic          notify_valid;
    logic [15:0]   notify_queue;
    logic          dev_reset;
    logic [43:0]   q_base;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] m_gf;
    int          m_sel;
    logic [7:0]  m_status;
    logic [7:0]  m_isr;
    logic [31:0] m_pfn [NQ];
    logic [7:0]  m_cfg [CLEN];

    logic        s_nv, s_rst;
    logic [15:0] s_nq;

    always #2 clk = ~clk;

    pvdev_regwin u_pvdev_regwin (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_req(irq_req), .irq(irq),
        .notify_valid(notify_valid), .notify_queue(notify_queue),
        .dev_reset(dev_reset), .q_base(q_base)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nb(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic void model_clear();
        m_gf = '0; m_sel = 0; m_status = '0; m_isr = '0;
        for (int q = 0; q < NQ; q++) m_pfn[q] = '0;
    endfunction

    function automatic logic [31:0] exp_read(input int a, input logic [1:0] s);
        logic [31:0] r;
        r = 32'hFFFF_FFFF;
        if (a >= 20 && a < WIN) begin
            r = '0;
            for (int k = 0; k < nb(s); k++)
                r[8*k +: 8] = (a - 20 + k < CLEN) ? m_cfg[a - 20 + k] : 8'hFF;
        end else begin
            case (a)
                0:  r = HF | 32'h5100_0000;
                4:  r = m_gf;
                8:  r = m_pfn[m_sel];
                12: r = 32'(128 * (m_sel + 1));
                14: r = 32'(m_sel);
                18: r = {24'h0, m_status};
                19: r = {24'h0, m_isr};
                default: r = 32'hFFFF_FFFF;
            endcase
        end
        return r;
    endfunction

    function automatic void model_write(input int a, input logic [1:0] s, input logic [31:0] d);
        if (a >= 20 && a < WIN) begin
            for (int k = 0; k < nb(s); k++)
                if (a - 20 + k < CLEN) m_cfg[a - 20 + k] = d[8*k +: 8];
        end else begin
            case (a)
                4:  m_gf = d[30] ? FB : d;
                8:  if (d == 0) model_clear(); else m_pfn[m_sel] = d;
                14: if (d[15:0] < NQ) m_sel = int'(d[15:0]);
                18: if (d[7:0] == 0) model_clear(); else m_status = d[7:0];
                default: ;
            endcase
        end
    endfunction

    task automatic bus_wr(input int a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(a); bus_size = s; bus_wdata = d;
        @(posedge clk); #1;
        s_nv = notify_valid; s_nq = notify_queue; s_rst = dev_reset;
        bus_valid = 1'b0;
        model_write(a, s, d);
        if (irq_req) m_isr[0] = 1'b1;
    endtask

    task automatic bus_rd(input int a, input logic [1:0] s, input string req);
        logic [31:0] e;
        e = exp_read(a, s);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(a); bus_size = s;
        #1;
        chk(bus_rdata == e, req, 64'(bus_rdata), 64'(e));
        @(posedge clk); #1;
        bus_valid = 1'b0;
        if (a == 19) m_isr = '0;
        if (irq_req) m_isr[0] = 1'b1;
    endtask

    task automatic pulse_irq();
        @(negedge clk); irq_req = 1'b1;
        @(posedge clk); #1; irq_req = 1'b0;
        m_isr[0] = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5171));
        model_clear();
        for (int b = 0; b < CLEN; b++) m_cfg[b] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        chk(irq == 0 && notify_valid == 0 && dev_reset == 0, "R1 outputs", 64'({irq, notify_valid, dev_reset}), 0);
        chk(q_base == 0, "R1 q_base", 64'(q_base), 0);
        foreach (m_pfn[i]) begin end
        bus_rd(4, 2, "R1 gfeat");
        bus_rd(14, 2, "R1 qsel");
        bus_rd(18, 2, "R1 status");
        bus_rd(19, 2, "R1 isr");
        // R2 host features, write ignored
        bus_wr(0, 2, 32'h0);
        bus_rd(0, 2, "R2 host features");
        // R3 accept and fallback
        bus_wr(4, 2, 32'h0000_00A5);
        bus_rd(4, 2, "R3 gfeat plain");
        bus_wr(4, 2, 32'h4000_00FF);
        bus_rd(4, 2, "R3 gfeat fallback");
        // R4 / R5 / R6 select, frame number, depth
        for (int q = 0; q < NQ; q++) begin
            bus_wr(14, 1, 32'(q));
            bus_wr(8, 2, 32'h100 + 32'(q));
            chk(q_base == {32'h100 + 32'(q), 12'h0}, "R5 q_base", 64'(q_base), 64'({32'h100 + 32'(q), 12'h0}));
            bus_rd(12, 2, "R6 depth");
        end
        bus_wr(14, 1, 32'd2);
        bus_wr(14, 1, 32'd4);
        bus_rd(14, 2, "R4 sel at NQ ignored");
        bus_wr(14, 1, 32'h0000_FFFF);
        bus_rd(14, 2, "R4 sel FFFF ignored");
        bus_rd(8, 2, "R5 pfn of sel 2");
        // R7 notify
        bus_wr(16, 1, 32'h0000_0003);
        chk(s_nv == 1 && s_nq == 16'd3, "R7 notify pulse", 64'({s_nv, s_nq}), 64'({1'b1, 16'd3}));
        #4;
        chk(notify_valid == 0, "R7 notify one cycle", 64'(notify_valid), 0);
        // R8 status
        bus_wr(18, 0, 32'hABCD_1207);
        bus_rd(18, 2, "R8 status");
        // R13 config
        bus_wr(20, 2, 32'h4433_2211);
        bus_wr(24, 1, 32'h0000_6655);
        bus_wr(27, 0, 32'h0000_0077);
        bus_rd(20, 2, "R13 cfg word");
        bus_rd(25, 1, "R13 cfg half");
        bus_rd(26, 2, "R13 cfg past end");
        bus_wr(28, 2, 32'hDEAD_BEEF);
        bus_rd(27, 1, "R13 cfg write past end dropped");
        // R10 / R11 interrupt status
        pulse_irq();
        chk(irq == 1, "R11 irq set", 64'(irq), 1);
        bus_rd(19, 2, "R10 isr read");
        chk(irq == 0, "R10 irq dropped", 64'(irq), 0);
        pulse_irq();
        @(negedge clk); irq_req = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(19); bus_size = 2'd0;
        #1; chk(bus_rdata == 32'h1, "R11 read value", 64'(bus_rdata), 1);
        @(posedge clk); #1; bus_valid = 1'b0; irq_req = 1'b0;
        chk(irq == 1, "R11 set wins over read", 64'(irq), 1);
        m_isr = 8'h01;
        // R12 holes and beyond window
        bus_rd(1, 2, "R12 hole 1");
        bus_rd(13, 2, "R12 hole 13");
        bus_rd(16, 2, "R12 notify read");
        bus_rd(33, 2, "R12 beyond window");
        bus_wr(36, 2, 32'h1234_5678);
        bus_rd(20, 2, "R12 write beyond ignored");
        // R9 reset by zero status
        bus_wr(18, 0, 32'h0000_0000);
        chk(s_rst == 1, "R9 status-zero reset pulse", 64'(s_rst), 1);
        chk(q_base == 0 && irq == 0, "R9 cleared", 64'({q_base, irq}), 0);
        bus_rd(4, 2, "R9 gfeat cleared");
        bus_rd(20, 2, "R9 cfg kept");
        // R9 reset by zero frame number
        bus_wr(14, 1, 32'd1);
        bus_wr(8, 2, 32'h55);
        bus_wr(18, 0, 32'h0F);
        bus_wr(8, 2, 32'h0);
        chk(s_rst == 1, "R9 pfn-zero reset pulse", 64'(s_rst), 1);
        bus_rd(14, 2, "R9 sel cleared");
        bus_rd(18, 2, "R9 status cleared");
        bus_wr(14, 1, 32'd1);
        bus_rd(8, 2, "R9 pfn q1 cleared");
        // random mix
        for (int n = 0; n < 400; n++) begin
            int op; int a; logic [1:0] s; logic [31:0] d;
            op = int'($urandom_range(0, 9));
            a  = int'($urandom_range(0, 39));
            s  = 2'($urandom_range(0, 2));
            d  = $urandom;
            if ($urandom_range(0, 7) == 0) d = 32'h0;
            if (a == 14) d = 32'($urandom_range(0, 6));
            if (op < 4) bus_wr(a, s, d);
            else if (op < 9) bus_rd(a, s, "R13 random read");
            else begin
                pulse_irq();
                chk(irq == 1, "R11 random irq", 64'(irq), 1);
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule